// File: doc/BRIEF.md
# Twin-Precision Signed Booth Multiplier

This block multiplies two signed N-bit operands with one radix-4 Booth partial-product array. A mode input picks how the array is used. In full mode it forms one signed N-by-N product, 2N bits wide. In twin mode the same array is cut at its middle, and two independent signed (N/2)-by-(N/2) products come out in the same cycle. One is formed from the low halves of both operands and one from the high halves. Each result is a sign-correct N-bit value in its own half of the output word.

Each pair of multiplier bits is recoded into a Booth digit that selects zero, plus or minus one times, or plus or minus two times the multiplicand. Only N/2 partial-product rows go to a binary tree of adders, because each row's negate bit is folded into the next row. The last row's negate bit enters the root adder as a third input. The mode signal reaches only the places where full and twin operation differ: the sign and constant bits of each row, the lowest recoding bit of the first high-half row, the multiplicand slice, and the carry between the two halves of every adder.

The width N is a parameter with default 16. It must be a multiple of 8, and any other value stops elaboration with an error. An optional output register, on by default, holds the product for one cycle.

Top module: `tpm_mult`

## Requirements
- R1: With `twin_i` = 0, `prod_o` equals the signed product of `mcand_i` and `mplier_i` as a 2N-bit two's-complement value; most-negative times most-negative gives 2^(2N-2) (0x4000_0000 for N = 16).
- R2: The multiplier is recoded per bit pair i from the triple (bit 2i+1, bit 2i, bit 2i-1): 000 and 111 select 0, 001 and 010 select +1, 011 selects +2, 100 selects -2, 101 and 110 select -1. The bit below bit 0 is 0, and in twin mode the bit below bit N/2 is also taken as 0.
- R3: With `twin_i` = 1, `prod_o[N-1:0]` equals the signed product of `mcand_i[N/2-1:0]` and `mplier_i[N/2-1:0]`, as an N-bit value.
- R4: With `twin_i` = 1, `prod_o[2N-1:N]` equals the signed product of `mcand_i[N-1:N/2]` and `mplier_i[N-1:N/2]`, as an N-bit value.
- R5: In twin mode no bit or carry crosses between halves: the low result does not depend on the high operand halves, and the high result does not depend on the low operand halves.
- R6: A zero multiplicand gives an all-zero `prod_o` in either mode.
- R7: Minus one times minus one gives 1 in full mode and gives 1 in each half in twin mode; in twin mode each half's most-negative squared gives 2^(N-2).
- R8: With the output register enabled, `prod_o` is 0 while `rst_n` is low and shows the product of the inputs present at the previous rising clock edge; the mode may change on any cycle and no state carries from one product to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| twin_i | input | 1 | 0 = one full-width product, 1 = two half-width products |
| mcand_i | input | N | Signed multiplicand (two signed halves in twin mode) |
| mplier_i | input | N | Signed multiplier (two signed halves in twin mode) |
| prod_o | output | 2N | Full product, or {high-half product, low-half product} |

## Verification
In twin mode the two half-products are formed in the same cycle from one array, so a carry or stray sign bit from one can corrupt the other. The bench provokes this by giving the halves opposing extremes at once, such as most-negative squared in one half against minus one squared in the other. It also holds one half fixed while the other half's operands are randomised. Each half is then judged against its own behavioural reference, and the fixed half must not move.

// File: rtl/tpm_pkg.sv
`timescale 1ns/1ps
package tpm_pkg;

    typedef enum logic [2:0] {
        DIG_ZERO,
        DIG_POS1,
        DIG_POS2,
        DIG_NEG1,
        DIG_NEG2
    } booth_digit_e;

    // Radix-4 recoding of one overlapping multiplier triple (R2)
    function automatic booth_digit_e decode_triple(input logic [2:0] t);
        booth_digit_e d;
        unique case (t)
            3'b000, 3'b111: d = DIG_ZERO;
            3'b001, 3'b010: d = DIG_POS1;
            3'b011:         d = DIG_POS2;
            3'b100:         d = DIG_NEG2;
            default:        d = DIG_NEG1;
        endcase
        return d;
    endfunction

    // Bit weight of the lowest bit of partial-product row idx
    function automatic int row_base(input int idx, input logic twin, input int n);
        int b;
        if (twin && idx >= n / 4) b = n + 2 * (idx - n / 4);
        else                      b = 2 * idx;
        return b;
    endfunction

endpackage

// File: rtl/tpm_booth_enc.sv
`timescale 1ns/1ps
module tpm_booth_enc
    import tpm_pkg::*;
(
    input  logic [2:0] trip_i,
    output logic       one_o,
    output logic       two_o,
    output logic       neg_o
);

    booth_digit_e dig;

    always_comb begin
        dig = decode_triple(trip_i);
    end

    always_comb begin
        one_o = 1'b0;
        two_o = 1'b0;
        neg_o = 1'b0;
        unique case (dig)
            DIG_ZERO: ;
            DIG_POS1: one_o = 1'b1;
            DIG_POS2: two_o = 1'b1;
            DIG_NEG1: begin one_o = 1'b1; neg_o = 1'b1; end
            DIG_NEG2: begin two_o = 1'b1; neg_o = 1'b1; end
            default:  ;
        endcase
    end

endmodule

// File: rtl/tpm_pp_row.sv
`timescale 1ns/1ps
module tpm_pp_row
    import tpm_pkg::*;
#(
    parameter int N   = 16,
    parameter int IDX = 0
) (
    input  logic           twin_i,
    input  logic [N-1:0]   mcand_i,
    input  logic [2:0]     trip_i,
    input  logic           neg_in_i,
    output logic [2*N-1:0] row_o,
    output logic           neg_o
);

    localparam int H  = N / 2;
    localparam int MH = N / 4;
    localparam int AW = $clog2(2 * N);
    localparam int FW = $clog2(N + 1);

    logic         sel_one, sel_two, sel_neg;
    logic [N:0]   xs, mag, fld;
    logic         sgn, first;
    int           w, base, pbase;

    tpm_booth_enc u_enc (
        .trip_i (trip_i),
        .one_o  (sel_one),
        .two_o  (sel_two),
        .neg_o  (sel_neg)
    );

    assign neg_o = sel_neg;

    // Multiplicand slice, sign-extended to N+1 bits
    always_comb begin
        if (!twin_i)         xs = {mcand_i[N-1], mcand_i};
        else if (IDX < MH)   xs = {{(H+1){mcand_i[H-1]}}, mcand_i[H-1:0]};
        else                 xs = {{(H+1){mcand_i[N-1]}}, mcand_i[N-1:H]};
        if (sel_one)         mag = xs;
        else if (sel_two)    mag = {xs[N-1:0], 1'b0};
        else                 mag = '0;
        fld = sel_neg ? ~mag : mag;
    end

    // Place field, sign-extension-prevention bits and folded negate bit
    always_comb begin
        w     = twin_i ? H : N;
        base  = row_base(IDX, twin_i, N);
        pbase = row_base(IDX - 1, twin_i, N);
        first = (IDX == 0) || (twin_i && (IDX == MH));
        sgn   = fld[FW'(w)];
        row_o = '0;
        for (int k = 0; k <= N; k++) begin
            if (k <= w) row_o[AW'(base + k)] = fld[FW'(k)];
        end
        if (first) begin
            row_o[AW'(base + w + 1)] = sgn;
            row_o[AW'(base + w + 2)] = ~sgn;
        end else begin
            row_o[AW'(base + w)]     = ~sgn;
            row_o[AW'(base + w + 1)] = 1'b1;
        end
        if (IDX > 0) row_o[AW'(pbase)] = neg_in_i;
    end

endmodule

// File: rtl/tpm_sum_tree.sv
`timescale 1ns/1ps
module tpm_sum_tree #(
    parameter int N    = 16,
    parameter int ROWS = 8
) (
    input  logic                     twin_i,
    input  logic [ROWS-1:0][2*N-1:0] rows_i,
    input  logic [2*N-1:0]           inj_i,
    output logic [2*N-1:0]           sum_o
);

    localparam int P = 1 << $clog2(ROWS);

    // Three-input add whose half-to-half carry is cut in twin mode
    function automatic logic [2*N-1:0] split_add(
        input logic [2*N-1:0] a,
        input logic [2*N-1:0] b,
        input logic [2*N-1:0] c,
        input logic           link
    );
        logic [N+1:0] lo;
        logic [N-1:0] hi;
        lo = {2'b00, a[N-1:0]} + {2'b00, b[N-1:0]} + {2'b00, c[N-1:0]};
        hi = a[2*N-1:N] + b[2*N-1:N] + c[2*N-1:N]
           + (link ? {{(N-2){1'b0}}, lo[N+1:N]} : {N{1'b0}});
        return {hi, lo[N-1:0]};
    endfunction

    logic [2*P-2:0][2*N-1:0] node;

    for (genvar j = 0; j < P; j++) begin : g_leaf
        if (j < ROWS) begin : g_used
            assign node[P-1+j] = rows_i[j];
        end else begin : g_pad
            assign node[P-1+j] = '0;
        end
    end

    for (genvar j = 0; j < P - 1; j++) begin : g_add
        if (j == 0) begin : g_root
            assign node[j] = split_add(node[2*j+1], node[2*j+2], inj_i, ~twin_i);
        end else begin : g_inner
            assign node[j] = split_add(node[2*j+1], node[2*j+2], '0, ~twin_i);
        end
    end

    assign sum_o = node[0];

endmodule

// File: rtl/tpm_mult.sv
`timescale 1ns/1ps
module tpm_mult #(
    parameter int N       = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           twin_i,
    input  logic [N-1:0]   mcand_i,
    input  logic [N-1:0]   mplier_i,
    output logic [2*N-1:0] prod_o
);

    localparam int H  = N / 2;
    localparam int M  = N / 2;
    localparam int MH = N / 4;
    localparam int AW = $clog2(2 * N);
    localparam logic [N-1:0]   MOST_NEG  = {1'b1, {(N-1){1'b0}}};
    localparam logic [2*N-1:0] MIN_SQ    = {2'b01, {(2*N-2){1'b0}}};

    if ((N % 8) != 0 || N < 8) begin : g_bad_width
        $error("tpm_mult: N must be a positive multiple of 8");
    end

    logic [M-1:0][2*N-1:0] rows;
    logic [M:0]            neg_chain;
    logic [2*N-1:0]        inj, sum;

    assign neg_chain[0] = 1'b0;

    for (genvar i = 0; i < M; i++) begin : g_row
        logic lsb;
        if (i == 0) begin : g_first
            assign lsb = 1'b0;
        end else if (i == MH) begin : g_split
            assign lsb = twin_i ? 1'b0 : mplier_i[2*i-1];
        end else begin : g_mid
            assign lsb = mplier_i[2*i-1];
        end
        tpm_pp_row #(.N(N), .IDX(i)) u_row (
            .twin_i   (twin_i),
            .mcand_i  (mcand_i),
            .trip_i   ({mplier_i[2*i+1], mplier_i[2*i], lsb}),
            .neg_in_i (neg_chain[i]),
            .row_o    (rows[i]),
            .neg_o    (neg_chain[i+1])
        );
    end

    // Negate bit of the last row has no free slot in any row: root input
    always_comb begin
        inj = '0;
        if (twin_i) inj[AW'(N + H - 2)] = neg_chain[M];
        else        inj[AW'(N - 2)]     = neg_chain[M];
    end

    tpm_sum_tree #(.N(N), .ROWS(M)) u_tree (
        .twin_i (twin_i),
        .rows_i (rows),
        .inj_i  (inj),
        .sum_o  (sum)
    );

    if (OUT_REG) begin : g_reg
        logic [2*N-1:0] prod_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prod_q <= '0;
            else        prod_q <= sum;
        end

        assign prod_o = prod_q;

        a_r6_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
            (mcand_i == '0) |=> (prod_o == '0));

        a_r1_min_squared: assert property (@(posedge clk) disable iff (!rst_n)
            (!twin_i && mcand_i == MOST_NEG && mplier_i == MOST_NEG) |=> (prod_o == MIN_SQ));

        a_r1_sign_of_product: assert property (@(posedge clk) disable iff (!rst_n)
            (!twin_i && mcand_i != '0 && mplier_i != '0)
            |=> (prod_o[2*N-1] == $past(mcand_i[N-1] ^ mplier_i[N-1])));

        a_r5_low_half_isolated: assert property (@(posedge clk) disable iff (!rst_n)
            (twin_i && mcand_i[H-1:0] == '0) |=> (prod_o[N-1:0] == '0));

        a_r5_high_half_isolated: assert property (@(posedge clk) disable iff (!rst_n)
            (twin_i && mcand_i[N-1:H] == '0) |=> (prod_o[2*N-1:N] == '0));
    end else begin : g_comb
        assign prod_o = sum;
    end

endmodule

// File: tb/tpm_mult_test.sv
`timescale 1ns/1ps
module tpm_mult_test;

    localparam int N = 16;
    localparam int H = N / 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           twin = 1'b0;
    logic [N-1:0]   a = '0;
    logic [N-1:0]   b = '0;
    logic [2*N-1:0] p;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    tpm_mult #(.N(N), .OUT_REG(1'b1)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .twin_i   (twin),
        .mcand_i  (a),
        .mplier_i (b),
        .prod_o   (p)
    );

    function automatic logic [2*N-1:0] ref_full(input logic [N-1:0] x, input logic [N-1:0] y);
        logic signed [2*N-1:0] xe, ye, r;
        xe = {{N{x[N-1]}}, x};
        ye = {{N{y[N-1]}}, y};
        r  = xe * ye;
        return r;
    endfunction

    function automatic logic [N-1:0] ref_half(input logic [H-1:0] x, input logic [H-1:0] y);
        logic signed [N-1:0] xe, ye, r;
        xe = {{H{x[H-1]}}, x};
        ye = {{H{y[H-1]}}, y};
        r  = xe * ye;
        return r;
    endfunction

    function automatic logic [2*N-1:0] ref_twin(input logic [N-1:0] x, input logic [N-1:0] y);
        return {ref_half(x[N-1:H], y[N-1:H]), ref_half(x[H-1:0], y[H-1:0])};
    endfunction

    function automatic logic [2*N-1:0] ref_any(input logic m, input logic [N-1:0] x, input logic [N-1:0] y);
        return m ? ref_twin(x, y) : ref_full(x, y);
    endfunction

    task automatic check(input string tag, input logic [2*N-1:0] got, input logic [2*N-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // drive at a falling edge, the register captures at the next rising edge,
    // sample at the following falling edge
    task automatic run(input string tag, input logic m, input logic [N-1:0] x, input logic [N-1:0] y);
        @(negedge clk);
        twin = m; a = x; b = y;
        @(negedge clk);
        check(tag, p, ref_any(m, x, y));
    endtask

    initial begin
        logic [N-1:0] lo_a, lo_b;
        logic [2*N-1:0] old;
        void'($urandom(32'd20240611));

        // R8: reset holds output at zero even with nonzero operands
        a = 16'h7123; b = 16'h0F0F;
        repeat (3) @(negedge clk);
        check("R8 reset value", p, '0);
        rst_n = 1'b1;

        // R1: directed full-mode corners
        run("R1 min*min", 1'b0, 16'h8000, 16'h8000);
        run("R1 max*max", 1'b0, 16'h7FFF, 16'h7FFF);
        run("R1 min*max", 1'b0, 16'h8000, 16'h7FFF);
        run("R1 min*one", 1'b0, 16'h8000, 16'h0001);
        run("R7 full -1*-1", 1'b0, 16'hFFFF, 16'hFFFF);
        run("R6 full zero mcand", 1'b0, 16'h0000, 16'hBEEF);
        run("R6 full zero mplier", 1'b0, 16'h1234, 16'h0000);

        // R2: multiplier patterns that exercise every recoding triple
        run("R2 full 5555", 1'b0, 16'h3A7C, 16'h5555);
        run("R2 full AAAA", 1'b0, 16'h3A7C, 16'hAAAA);
        run("R2 full 3333", 1'b0, 16'hC581, 16'h3333);
        run("R2 full CCCC", 1'b0, 16'hC581, 16'hCCCC);
        run("R2 full 8000", 1'b0, 16'h0123, 16'h8000);
        run("R2 twin restart 0080", 1'b1, 16'h4567, 16'h0080);
        run("R2 twin restart 01FF", 1'b1, 16'h9ABC, 16'h01FF);
        run("R2 twin restart 8080", 1'b1, 16'h7F7F, 16'h8080);

        // R3/R4/R7: twin-mode corners, halves at opposing extremes
        run("R7 twin min*min both", 1'b1, 16'h8080, 16'h8080);
        run("R7 twin -1*-1 both", 1'b1, 16'hFFFF, 16'hFFFF);
        run("R3 twin low min^2 high -1^2", 1'b1, 16'hFF80, 16'hFF80);
        run("R4 twin high min^2 low -1^2", 1'b1, 16'h80FF, 16'h80FF);
        run("R4 twin high max*min", 1'b1, 16'h7F01, 16'h80FF);
        run("R6 twin zero mcand", 1'b1, 16'h0000, 16'hA5A5);

        // R8: output holds the old product until the next rising edge,
        // then follows a mode change with no memory of the previous product
        @(negedge clk);
        twin = 1'b0; a = 16'h1357; b = 16'hF00D;
        @(negedge clk);
        old = ref_full(16'h1357, 16'hF00D);
        check("R8 full product", p, old);
        twin = 1'b1; a = 16'h8001; b = 16'h7FFE;
        #1;
        check("R8 hold before edge", p, old);
        @(negedge clk);
        check("R8 mode switch to twin", p, ref_twin(16'h8001, 16'h7FFE));
        run("R8 mode switch back to full", 1'b0, 16'h8001, 16'h7FFE);

        // R5: low halves fixed, high halves random
        lo_a = 16'h0081; lo_b = 16'h007F;
        for (int i = 0; i < 60; i++) begin
            logic [H-1:0] ha, hb;
            ha = H'($urandom); hb = H'($urandom);
            @(negedge clk);
            twin = 1'b1; a = {ha, lo_a[H-1:0]}; b = {hb, lo_b[H-1:0]};
            @(negedge clk);
            check("R5 low half unaffected", {{N{1'b0}}, p[N-1:0]},
                  {{N{1'b0}}, ref_half(lo_a[H-1:0], lo_b[H-1:0])});
        end
        // R5: high halves fixed, low halves random
        for (int i = 0; i < 60; i++) begin
            logic [H-1:0] la, lb;
            la = H'($urandom); lb = H'($urandom);
            @(negedge clk);
            twin = 1'b1; a = {8'h80, la}; b = {8'hFF, lb};
            @(negedge clk);
            check("R5 high half unaffected", {p[2*N-1:N], {N{1'b0}}},
                  {ref_half(8'h80, 8'hFF), {N{1'b0}}});
        end

        // R1: random full-mode vectors
        for (int i = 0; i < 400; i++) begin
            run("R1 random full", 1'b0, N'($urandom), N'($urandom));
        end
        // R3/R4: random twin-mode vectors
        for (int i = 0; i < 400; i++) begin
            run("R3 R4 random twin", 1'b1, N'($urandom), N'($urandom));
        end
        // R8: random mode every cycle
        for (int i = 0; i < 200; i++) begin
            run("R8 random mode", 1'($urandom), N'($urandom), N'($urandom));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule